// File: doc/BRIEF.md
# Far-End Alarm Code Receiver

This block sits behind a DS3 framer and listens to the far-end alarm and control channel, which carries one bit per DS3 frame. Each bit arrives with a one-cycle strobe. The block looks for a 16-bit message that carries a 6-bit alarm code. In transmission order, a message is eight ones, a zero, the code from its low bit d0 up to d5, and a closing zero.

Every message that fits this pattern enters a history of the last ten framed messages. A code is declared valid once it fills at least eight of those ten slots. A valid code is declared removed once it fills fewer than three of them. The last validated code stays readable in a code register. A status register holds the valid flag, two sticky event bits (one for validation, one for removal) that clear when read, and their two enable bits. The interrupt line is the OR of each event bit ANDed with its enable.

Top module: `feac_rx`

## Requirements
- R1: A message is framed only when the last 16 strobed bits are, oldest first, eight 1s, a 0, six code bits and a 0. After a framed message the search starts afresh, so the next 16 strobed bits must form a whole new message. Bit patterns that do not match are not entered into the history.
- R2: The code register (reg_sel_i=0) reads {2'b00, d5..d0}, where d0 is the first code bit received. It changes only when a code is validated, and it keeps its value after a removal.
- R3: While no code is valid, a framed message whose code then occupies at least 8 of the last 10 history slots validates that code. This sets the valid flag (status bit 4) and the valid event bit (status bit 0).
- R4: While a code is valid, a framed message that leaves that code in fewer than 3 of the last 10 slots clears the valid flag and sets the remove event bit (status bit 2). Validation is not evaluated on that same message.
- R5: The status register (reg_sel_i=1) reads {3'b000, valid, remove enable, remove event, valid enable, valid event}. A write changes only the enables, bit 3 and bit 1. The other bits ignore writes.
- R6: A status read (reg_rd_i with reg_sel_i=1) clears both event bits on the following edge. An event that occurs in that same cycle takes precedence over the clear.
- R7: irq_o is high exactly when (valid event AND valid enable) OR (remove event AND remove enable).
- R8: After reset, the history is empty, both registers read zero and irq_o is low.
- R9: bit_i is ignored in cycles where bit_vld_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Alarm channel bit |
| bit_vld_i | input | 1 | Strobe marking bit_i as valid, once per DS3 frame |
| reg_sel_i | input | 1 | Register select: 0 for the code register, 1 for the status register |
| reg_rd_i | input | 1 | Read strobe; reading the status register clears its event bits |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Contents of the selected register (combinational) |
| irq_o | output | 1 | Interrupt |

## Verification
The assertions check these rules on every cycle:
- A framed message always follows a strobe.
- The valid flag rises only right after a framed message, and it is low on the cycle after a removal.
- Validation and removal never occur on the same message.
- The code register holds its value unless a validation occurs.
- The event bits are set by their events and cleared by status reads.

Only the bench scenarios can show the counting behaviour:
- Validation lands exactly on the eighth matching message.
- Removal lands exactly on the eighth replacement message, and the new code follows on the ninth.
- Malformed patterns are kept out of the history.
- The code bits come out in the right order.

// File: rtl/feac_pkg.sv
package feac_pkg;
  localparam int FEAC_CW   = 6;   // code bits per message
  localparam int FEAC_ONES = 8;   // leading ones
  localparam int FEAC_WIN  = 10;  // history depth
  localparam int FEAC_VAL  = 8;   // occurrences needed to validate
  localparam int FEAC_REM  = 3;   // below this a valid code is removed

  localparam int ST_VAL_EV = 0;
  localparam int ST_VAL_EN = 1;
  localparam int ST_REM_EV = 2;
  localparam int ST_REM_EN = 3;
  localparam int ST_VALID  = 4;
endpackage

// File: rtl/feac_framer.sv
module feac_framer #(
  parameter int CW   = feac_pkg::FEAC_CW,
  parameter int ONES = feac_pkg::FEAC_ONES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_i,
  input  logic          bit_vld_i,
  output logic          frm_o,
  output logic [CW-1:0] code_o
);
  localparam int MSG   = ONES + CW + 2;
  localparam int FIL_W = $clog2(MSG + 1);

  logic [MSG-1:0]   sh_q;
  logic [MSG-1:0]   nxt;
  logic [FIL_W-1:0] fill_q;
  logic             hit;
  logic [CW-1:0]    code_n;

  assign nxt = {sh_q[MSG-2:0], bit_i};

  // oldest bit at MSB: ones, zero, d0..d5, zero
  assign hit = (fill_q >= FIL_W'(MSG - 1)) && (&nxt[MSG-1:CW+2])
             && !nxt[CW+1] && !nxt[0];

  for (genvar k = 0; k < CW; k++) begin : g_code
    assign code_n[k] = nxt[CW - k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      fill_q <= '0;
      frm_o  <= 1'b0;
      code_o <= '0;
    end else begin
      frm_o <= 1'b0;
      if (bit_vld_i) begin
        sh_q <= nxt;
        if (hit) begin
          fill_q <= '0;
          frm_o  <= 1'b1;
          code_o <= code_n;
        end else if (fill_q != FIL_W'(MSG)) begin
          fill_q <= fill_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/feac_window.sv
module feac_window #(
  parameter int CW  = feac_pkg::FEAC_CW,
  parameter int WIN = feac_pkg::FEAC_WIN,
  parameter int VAL = feac_pkg::FEAC_VAL,
  parameter int REM = feac_pkg::FEAC_REM
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frm_i,
  input  logic [CW-1:0] code_i,
  output logic          valid_o,
  output logic [CW-1:0] code_o,
  output logic          val_evt_o,
  output logic          rem_evt_o
);
  localparam int CNT_W = $clog2(WIN + 1);

  logic [CW-1:0]    slot_q [WIN];
  logic [WIN-1:0]   used_q;
  logic [CW-1:0]    slot_n [WIN];
  logic [WIN-1:0]   used_n;
  logic [CNT_W-1:0] cnt_new, cnt_held;

  assign slot_n[0] = code_i;
  assign used_n[0] = 1'b1;
  for (genvar i = 1; i < WIN; i++) begin : g_shift
    assign slot_n[i] = slot_q[i-1];
    assign used_n[i] = used_q[i-1];
  end

  always_comb begin
    cnt_new  = '0;
    cnt_held = '0;
    for (int i = 0; i < WIN; i++) begin
      if (used_n[i] && slot_n[i] == code_i) cnt_new  = cnt_new + 1'b1;
      if (used_n[i] && slot_n[i] == code_o) cnt_held = cnt_held + 1'b1;
    end
  end

  assign val_evt_o = frm_i && !valid_o && (cnt_new >= CNT_W'(VAL));
  assign rem_evt_o = frm_i &&  valid_o && (cnt_held < CNT_W'(REM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q  <= '0;
      valid_o <= 1'b0;
      code_o  <= '0;
      for (int i = 0; i < WIN; i++) slot_q[i] <= '0;
    end else if (frm_i) begin
      used_q <= used_n;
      for (int i = 0; i < WIN; i++) slot_q[i] <= slot_n[i];
      if (val_evt_o) begin
        valid_o <= 1'b1;
        code_o  <= code_i;
      end else if (rem_evt_o) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/feac_regs.sv
module feac_regs #(
  parameter int CW = feac_pkg::FEAC_CW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [CW-1:0] code_i,
  input  logic          val_evt_i,
  input  logic          rem_evt_i,
  input  logic          sel_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic [7:0]    stat_o,
  output logic          irq_o
);
  import feac_pkg::*;

  logic val_ev_q, val_en_q, rem_ev_q, rem_en_q;
  logic clr;

  assign clr = rd_i && sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_ev_q <= 1'b0;
      rem_ev_q <= 1'b0;
      val_en_q <= 1'b0;
      rem_en_q <= 1'b0;
    end else begin
      if (val_evt_i)  val_ev_q <= 1'b1;
      else if (clr)   val_ev_q <= 1'b0;
      if (rem_evt_i)  rem_ev_q <= 1'b1;
      else if (clr)   rem_ev_q <= 1'b0;
      if (wr_i && sel_i) begin
        val_en_q <= wdata_i[ST_VAL_EN];
        rem_en_q <= wdata_i[ST_REM_EN];
      end
    end
  end

  always_comb begin
    stat_o            = '0;
    stat_o[ST_VAL_EV] = val_ev_q;
    stat_o[ST_VAL_EN] = val_en_q;
    stat_o[ST_REM_EV] = rem_ev_q;
    stat_o[ST_REM_EN] = rem_en_q;
    stat_o[ST_VALID]  = valid_i;
  end

  assign rdata_o = sel_i ? stat_o : {{(8-CW){1'b0}}, code_i};
  assign irq_o   = (val_ev_q && val_en_q) || (rem_ev_q && rem_en_q);
endmodule

// File: rtl/feac_rx.sv
module feac_rx #(
  parameter int CW   = feac_pkg::FEAC_CW,
  parameter int ONES = feac_pkg::FEAC_ONES,
  parameter int WIN  = feac_pkg::FEAC_WIN,
  parameter int VAL  = feac_pkg::FEAC_VAL,
  parameter int REM  = feac_pkg::FEAC_REM
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  input  logic       bit_vld_i,
  input  logic       reg_sel_i,
  input  logic       reg_rd_i,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o
);
  logic          frm_vld;
  logic [CW-1:0] frm_code;
  logic          win_valid;
  logic [CW-1:0] win_code;
  logic          val_evt, rem_evt;
  logic [7:0]    stat;

  feac_framer #(.CW(CW), .ONES(ONES)) u_framer (
    .clk_i, .rst_ni, .bit_i, .bit_vld_i,
    .frm_o(frm_vld), .code_o(frm_code)
  );

  feac_window #(.CW(CW), .WIN(WIN), .VAL(VAL), .REM(REM)) u_window (
    .clk_i, .rst_ni,
    .frm_i(frm_vld), .code_i(frm_code),
    .valid_o(win_valid), .code_o(win_code),
    .val_evt_o(val_evt), .rem_evt_o(rem_evt)
  );

  feac_regs #(.CW(CW)) u_regs (
    .clk_i, .rst_ni,
    .valid_i(win_valid), .code_i(win_code),
    .val_evt_i(val_evt), .rem_evt_i(rem_evt),
    .sel_i(reg_sel_i), .rd_i(reg_rd_i), .wr_i(reg_wr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .stat_o(stat), .irq_o(irq_o)
  );
endmodule

// File: rtl/feac_rx_chk.sv
module feac_rx_chk #(
  parameter int CW = feac_pkg::FEAC_CW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bit_vld_i,
  input logic          reg_sel_i,
  input logic          reg_rd_i,
  input logic [7:0]    reg_rdata_o,
  input logic          frm_vld,
  input logic          win_valid,
  input logic [CW-1:0] win_code,
  input logic          val_evt,
  input logic          rem_evt,
  input logic          val_ev_st,
  input logic          rem_ev_st
);
  assert_frame_after_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld |-> $past(bit_vld_i));

  assert_code_hi_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> reg_rdata_o[7:6] == 2'b00);

  assert_code_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !val_evt |=> $stable(win_code));

  assert_valid_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_valid) |-> $past(frm_vld));

  assert_no_dual_event_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(val_evt && rem_evt));

  assert_remove_drops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_evt |=> !win_valid);

  assert_event_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_evt |=> val_ev_st) and (rem_evt |=> rem_ev_st));

  assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_sel_i && !val_evt && !rem_evt) |=> (!val_ev_st && !rem_ev_st));
endmodule

bind feac_rx feac_rx_chk #(.CW(CW)) u_chk (
  .clk_i, .rst_ni, .bit_vld_i, .reg_sel_i, .reg_rd_i, .reg_rdata_o,
  .frm_vld, .win_valid, .win_code, .val_evt, .rem_evt,
  .val_ev_st(stat[0]), .rem_ev_st(stat[2])
);

// File: tb/feac_rx_bench.sv
module feac_rx_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_i = 1'b0;
  logic       bit_vld_i = 1'b0;
  logic       reg_sel_i = 1'b0;
  logic       reg_rd_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  feac_rx u_feac_rx (.*);

  localparam logic [5:0] CA = 6'h0B;
  localparam logic [5:0] CB = 6'h0C;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // strobed bit followed by an unstrobed inverted bit (R9 noise)
  task automatic put_bit(logic b);
    bit_vld_i = 1'b1;
    bit_i = b;
    @(negedge clk_i);
    bit_vld_i = 1'b0;
    bit_i = ~b;
    @(negedge clk_i);
  endtask

  task automatic send_msg(logic [5:0] c, logic tail);
    for (int i = 0; i < 8; i++) put_bit(1'b1);
    put_bit(1'b0);
    for (int i = 0; i < 6; i++) put_bit(c[i]);
    put_bit(tail);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic send_n(logic [5:0] c, int n);
    for (int i = 0; i < n; i++) send_msg(c, 1'b0);
  endtask

  task automatic peek(logic sel, output logic [7:0] v);
    reg_sel_i = sel;
    #1 v = reg_rdata_o;
  endtask

  task automatic rd_status(output logic [7:0] v);
    reg_sel_i = 1'b1;
    reg_rd_i = 1'b1;
    #1 v = reg_rdata_o;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
  endtask

  task automatic wr_status(logic [7:0] d);
    reg_sel_i = 1'b1;
    reg_wr_i = 1'b1;
    reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    peek(1'b1, v); chk("R8 status", v, 8'h00);
    peek(1'b0, v); chk("R8 code", v, 8'h00);
    chk("R8 irq", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_validate();
    logic [7:0] v;
    do_reset();
    send_n(CA, 7);
    peek(1'b1, v); chk("R3 seven not valid", v, 8'h00);
    send_n(CA, 1);
    peek(1'b1, v); chk("R3 eighth valid", v, 8'h11);
    peek(1'b0, v); chk("R2 code order", v, {2'b00, CA});
    chk("R7 irq masked", {7'b0, irq_o}, 8'h00);
    wr_status(8'h02);
    chk("R7 irq enabled", {7'b0, irq_o}, 8'h01);
    rd_status(v); chk("R6 read value", v, 8'h13);
    peek(1'b1, v); chk("R6 cleared", v, 8'h12);
    chk("R7 irq after clear", {7'b0, irq_o}, 8'h00);
    send_n(CA, 2);
    peek(1'b1, v); chk("R3 no re-event", v, 8'h12);
  endtask

  task automatic t_remove();
    logic [7:0] v;
    wr_status(8'h0A);
    rd_status(v);
    send_n(CB, 7);
    peek(1'b1, v); chk("R4 still valid", v, 8'h1A);
    send_n(CB, 1);
    peek(1'b1, v); chk("R4 removed", v, 8'h0E);
    peek(1'b0, v); chk("R2 code kept", v, {2'b00, CA});
    chk("R7 remove irq", {7'b0, irq_o}, 8'h01);
    send_n(CB, 1);
    peek(1'b1, v); chk("R3 new code valid", v, 8'h1F);
    peek(1'b0, v); chk("R2 new code", v, {2'b00, CB});
    rd_status(v); chk("R6 read both", v, 8'h1F);
    peek(1'b1, v); chk("R6 both cleared", v, 8'h1A);
  endtask

  task automatic t_write_ro();
    logic [7:0] v;
    wr_status(8'hF5);
    peek(1'b1, v); chk("R5 ro bits", v, 8'h10);
    chk("R7 irq off", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_malformed();
    logic [7:0] v;
    do_reset();
    send_n(CA, 3);
    for (int i = 0; i < 4; i++) send_msg(CA, 1'b1);
    send_n(CA, 4);
    peek(1'b1, v); chk("R1 bad not counted 7", v, 8'h00);
    send_n(CA, 1);
    peek(1'b1, v); chk("R1 bad not counted 8", v, 8'h11);
  endtask

  initial begin
    t_reset();
    t_validate();
    t_remove();
    t_write_ro();
    t_malformed();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule